// File: doc/BRIEF.md
# Threshold-Started DMA Burst Requester

This block decides when a byte FIFO, placed between a parallel port and a 16-bit host bus, should ask the system DMA engine for service. In receive mode (port to host) it asks once the FIFO holds more bytes than a programmed threshold. In transmit mode (host to port) it asks once the FIFO holds fewer bytes than that threshold.

The request is hysteretic. Once raised, it stays asserted through any number of acknowledged 16-bit word transfers. It drops only when the FIFO can no longer supply a whole word (receive) or accept a whole word (transmit). Each acknowledge, taken on its falling edge, produces a one-cycle transfer strobe for the matching direction, so the FIFO can pop or push two bytes. The request is also exposed as bit 7 of a status byte that software can poll.

Software that moves data through programmed I/O drops the enable and raises it again. This abandons any burst and makes the block evaluate the threshold afresh.

Top module: `dma_burst_req`

## Requirements
- R1: While reset is low and in the first cycle after it, `dma_req_n` is 1, both strobes are 0 and `dma_status` is 8'h00.
- R2: In receive mode (`dir_tx`=0), with enable high, the request goes active (`dma_req_n`=0) one clock after an edge at which `fill_count` > `thr` and `fill_count` >= 2. At `fill_count` equal to `thr` it does not start.
- R3: Once active in receive mode, the request stays active while `fill_count` >= 2, even below the threshold. It goes inactive one clock after an edge at which `fill_count` < 2.
- R4: In transmit mode (`dir_tx`=1), the request goes active one clock after an edge at which `fill_count` < `thr` and DEPTH - `fill_count` >= 2. At `fill_count` equal to `thr` it does not start.
- R5: Once active in transmit mode, the request stays active while DEPTH - `fill_count` >= 2. It goes inactive one clock after an edge at which fewer than two free bytes remain.
- R6: An edge with `dma_en`=0 makes `dma_req_n`=1 for the following cycle and discards the burst. After re-enable, a request starts only through the start condition of R2 or R4.
- R7: An acknowledge is counted when `dma_ack_n` is sampled 0 after having been sampled 1 at the previous edge, while enable is high and the request is active. In the next cycle `xfer_rx` (`dir_tx`=0) or `xfer_tx` (`dir_tx`=1) is 1 for exactly one cycle. An acknowledge held low longer gives one strobe only.
- R8: A falling acknowledge while the request is inactive or enable is low produces no strobe.
- R9: `dma_status[7]` is 1 exactly when `dma_req_n` is 0; bits 6:0 are always 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| dma_en | input | 1 | DMA enable; low clears and blocks the request |
| dir_tx | input | 1 | 0 = receive (port to host), 1 = transmit (host to port) |
| thr | input | 8 | Programmed start threshold in bytes |
| fill_count | input | 7 | Bytes currently held in the FIFO, 0 to DEPTH |
| dma_ack_n | input | 1 | DMA acknowledge, active low, one per word |
| dma_req_n | output | 1 | DMA request, active low |
| dma_status | output | 8 | Status byte; bit 7 = request active |
| xfer_rx | output | 1 | One-cycle strobe: pop one word to the host |
| xfer_tx | output | 1 | One-cycle strobe: push one word from the host |

## Verification
The assertions assume that `fill_count` never exceeds DEPTH, because the free-space arithmetic of transmit mode is only meaningful in that range. The random stimulus walks the fill level by at most two bytes per cycle and clamps it to 0..DEPTH. It changes threshold, direction and enable only occasionally, so that long hysteretic bursts form between the directed corner cases. Acknowledge is driven as random low pulses of varying length, which includes pulses that arrive while no request is active.

// File: rtl/dma_req_pkg.sv
// Package: shared types for the DMA burst requester.
// Assumes nothing beyond a single clock domain.
package dma_req_pkg;
    typedef enum logic {
        XDIR_RX = 1'b0,   // port to host: FIFO drains over the bus
        XDIR_TX = 1'b1    // host to port: FIFO fills over the bus
    } xdir_e;

    // Bytes carried by one acknowledged bus cycle.
    localparam int unsigned WORD_BYTES = 2;
endpackage

// File: rtl/dreq_level_eval.sv
// dreq_level_eval: combinational start/stop decision from FIFO level.
// Receive starts above the threshold and stops when less than a word
// remains; transmit starts below the threshold and stops when less than
// a word of free space remains. Assumes fill <= DEPTH.
module dreq_level_eval
    import dma_req_pkg::*;
#(
    parameter int unsigned DEPTH = 64,
    parameter int unsigned THR_W = 8,
    parameter int unsigned CNT_W = $clog2(DEPTH + 1)
) (
    input  xdir_e            dir,
    input  logic [THR_W-1:0] thr,
    input  logic [CNT_W-1:0] fill,
    output logic             start_ok,
    output logic             stop_now
);
    localparam int unsigned CMP_W = ((CNT_W > THR_W) ? CNT_W : THR_W) + 1;
    localparam logic [CMP_W-1:0] DEPTH_W = CMP_W'(DEPTH);
    localparam logic [CMP_W-1:0] WORD_W  = CMP_W'(WORD_BYTES);

    logic [CMP_W-1:0] fill_w;
    logic [CMP_W-1:0] thr_w;
    logic [CMP_W-1:0] free_w;

    // Widen operands to one common compare width.
    always_comb begin
        fill_w = CMP_W'(fill);
        thr_w  = CMP_W'(thr);
        free_w = DEPTH_W - fill_w;
    end

    // Select the per-direction start and stop conditions.
    always_comb begin
        if (dir == XDIR_RX) begin
            start_ok = fill_w > thr_w;
            stop_now = fill_w < WORD_W;
        end else begin
            start_ok = fill_w < thr_w;
            stop_now = free_w < WORD_W;
        end
    end
endmodule

// File: rtl/dreq_burst_ctrl.sv
// dreq_burst_ctrl: the hysteretic request register. The burst opens on
// a start condition and closes only on the stop condition or when the
// enable is low. Assumes start/stop come from dreq_level_eval.
module dreq_burst_ctrl (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    input  logic start_ok,
    input  logic stop_now,
    output logic req_active
);
    logic req_q;

    // Hold the burst once opened; enable low abandons it.
    always_ff @(posedge clk) begin
        if (!rst_n)
            req_q <= 1'b0;
        else
            req_q <= en && !stop_now && (req_q || start_ok);
    end

    assign req_active = req_q;

    AST_DISABLE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> !req_active);  // R6
    AST_HOLD_BURST: assert property (@(posedge clk) disable iff (!rst_n)
        (req_active && en && !stop_now) |=> req_active);  // R3
    AST_STOP_BURST: assert property (@(posedge clk) disable iff (!rst_n)
        stop_now |=> !req_active);  // R5
endmodule

// File: rtl/dreq_ack_strobe.sv
// dreq_ack_strobe: detects the falling edge of the active-low
// acknowledge and turns each qualified edge into one registered strobe
// in the current direction. Assumes the acknowledge is synchronous to clk.
module dreq_ack_strobe
    import dma_req_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  ack_n,
    input  logic  qualify,
    input  xdir_e dir,
    output logic  strobe_rx,
    output logic  strobe_tx
);
    logic ack_prev_q;
    logic rx_q;
    logic tx_q;
    logic fall;

    // Remember the previous acknowledge level for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n)
            ack_prev_q <= 1'b1;
        else
            ack_prev_q <= ack_n;
    end

    assign fall = ack_prev_q && !ack_n;

    // Register one strobe per qualified falling edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rx_q <= 1'b0;
            tx_q <= 1'b0;
        end else begin
            rx_q <= fall && qualify && (dir == XDIR_RX);
            tx_q <= fall && qualify && (dir == XDIR_TX);
        end
    end

    assign strobe_rx = rx_q;
    assign strobe_tx = tx_q;

    AST_SINGLE_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        (strobe_rx || strobe_tx) |=> !(strobe_rx || strobe_tx));  // R7
    AST_STROBE_NEEDS_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
        (strobe_rx || strobe_tx) |-> $past(qualify));  // R8
endmodule

// File: rtl/dma_burst_req.sv
// dma_burst_req: top of the threshold-started DMA burst requester.
// Ties level evaluation, the hysteretic request register and the
// acknowledge strobe generator together and forms the status byte.
// Assumes fill_count never exceeds DEPTH and all inputs are synchronous.
module dma_burst_req
    import dma_req_pkg::*;
#(
    parameter int unsigned DEPTH    = 64,
    parameter int unsigned THR_W    = 8,
    parameter int unsigned CNT_W    = $clog2(DEPTH + 1),
    parameter int unsigned STAT_W   = 8,
    parameter int unsigned STAT_BIT = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              dma_en,
    input  logic              dir_tx,
    input  logic [THR_W-1:0]  thr,
    input  logic [CNT_W-1:0]  fill_count,
    input  logic              dma_ack_n,
    output logic              dma_req_n,
    output logic [STAT_W-1:0] dma_status,
    output logic              xfer_rx,
    output logic              xfer_tx
);
    xdir_e dir;
    logic  start_ok;
    logic  stop_now;
    logic  req_active;
    logic  ack_qual;

    assign dir = dir_tx ? XDIR_TX : XDIR_RX;

    dreq_level_eval #(
        .DEPTH (DEPTH),
        .THR_W (THR_W),
        .CNT_W (CNT_W)
    ) u_level (
        .dir      (dir),
        .thr      (thr),
        .fill     (fill_count),
        .start_ok (start_ok),
        .stop_now (stop_now)
    );

    dreq_burst_ctrl u_burst (
        .clk        (clk),
        .rst_n      (rst_n),
        .en         (dma_en),
        .start_ok   (start_ok),
        .stop_now   (stop_now),
        .req_active (req_active)
    );

    assign ack_qual = dma_en && req_active;

    dreq_ack_strobe u_ack (
        .clk       (clk),
        .rst_n     (rst_n),
        .ack_n     (dma_ack_n),
        .qualify   (ack_qual),
        .dir       (dir),
        .strobe_rx (xfer_rx),
        .strobe_tx (xfer_tx)
    );

    assign dma_req_n = !req_active;

    // Place the request flag at its status bit, all other bits zero.
    always_comb begin
        dma_status           = '0;
        dma_status[STAT_BIT] = req_active;
    end

    AST_FILL_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        fill_count <= CNT_W'(DEPTH));  // R5
    AST_RX_START: assert property (@(posedge clk) disable iff (!rst_n)
        (dma_en && !dir_tx && (fill_count >= 2) && (32'(fill_count) > 32'(thr)))
        |=> !dma_req_n);  // R2
    AST_TX_START: assert property (@(posedge clk) disable iff (!rst_n)
        (dma_en && dir_tx && (32'(fill_count) + 2 <= DEPTH) && (32'(fill_count) < 32'(thr)))
        |=> !dma_req_n);  // R4
    AST_RX_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        (!dir_tx && fill_count < 2) |=> dma_req_n);  // R3
    AST_STROBE_DIR: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_rx |-> $past(!dir_tx));  // R7
endmodule

// File: tb/tb_dma_burst_req.sv
module tb_dma_burst_req;
    localparam int DEPTH = 64;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       dma_en = 1'b0;
    logic       dir_tx = 1'b0;
    logic [7:0] thr = 8'd0;
    logic [6:0] fill_count = 7'd0;
    logic       dma_ack_n = 1'b1;
    logic       dma_req_n;
    logic [7:0] dma_status;
    logic       xfer_rx;
    logic       xfer_tx;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    // reference state, updated from the requirements
    bit m_req = 0;
    bit m_ackp = 1;
    bit m_xrx = 0;
    bit m_xtx = 0;

    always #2.5 clk = ~clk;

    dma_burst_req dut (
        .clk(clk), .rst_n(rst_n), .dma_en(dma_en), .dir_tx(dir_tx),
        .thr(thr), .fill_count(fill_count), .dma_ack_n(dma_ack_n),
        .dma_req_n(dma_req_n), .dma_status(dma_status),
        .xfer_rx(xfer_rx), .xfer_tx(xfer_tx)
    );

    function automatic bit next_req(bit en, bit tx, int th, int fl, bit cur);
        bit st, sp;
        if (!tx) begin st = fl > th; sp = fl < 2; end
        else     begin st = fl < th; sp = (DEPTH - fl) < 2; end
        return en && !sp && (cur || st);
    endfunction

    task automatic chk(string tag, string what, int got, int exp);
        checks++;
        if (got != exp) begin
            errors++;
            $display("FAIL %s %s: got %0d expected %0d", tag, what, got, exp);
        end
    endtask

    task automatic compare(string tag);
        chk(tag, "dma_req_n", dma_req_n, !m_req);
        chk(tag, "xfer_rx", xfer_rx, m_xrx);
        chk(tag, "xfer_tx", xfer_tx, m_xtx);
        chk("R9", "dma_status", dma_status, m_req ? 8'h80 : 8'h00);
    endtask

    // apply inputs at the falling edge, advance the model, sample after the rise
    task automatic step(bit en, bit tx, int th, int fl, bit ack, string tag);
        bit hit;
        @(negedge clk);
        dma_en = en; dir_tx = tx; thr = 8'(th); fill_count = 7'(fl); dma_ack_n = ack;
        hit = en && m_req && m_ackp && !ack;
        @(posedge clk);
        #1;
        m_xrx = hit && !tx;
        m_xtx = hit && tx;
        m_req = next_req(en, tx, th, fl, m_req);
        m_ackp = ack;
        compare(tag);
    endtask

    initial begin
        int fl;
        int th;
        bit tx;
        bit en;
        bit ack;
        int low_left;
        void'($urandom(32'hC0FFEE));
        // R1: reset state
        repeat (3) @(posedge clk);
        #1;
        chk("R1", "dma_req_n", dma_req_n, 1);
        chk("R1", "xfer", {xfer_rx, xfer_tx}, 0);
        chk("R1", "status", dma_status, 0);
        @(negedge clk);
        rst_n = 1'b1;
        step(0, 0, 10, 40, 1, "R1");

        // R2 boundary: level equal to threshold does not start
        step(1, 0, 10, 10, 1, "R2");
        step(1, 0, 10, 11, 1, "R2");
        // R3: held below threshold, dropped below one word
        step(1, 0, 10, 5, 1, "R3");
        step(1, 0, 10, 2, 1, "R3");
        step(1, 0, 10, 1, 1, "R3");
        step(1, 0, 10, 5, 1, "R3");
        // R4 boundary then start
        step(1, 1, 20, 20, 1, "R4");
        step(1, 1, 20, 19, 1, "R4");
        // R5: held above threshold, dropped with one free byte
        step(1, 1, 20, 62, 1, "R5");
        step(1, 1, 20, 63, 1, "R5");
        step(1, 1, 20, 30, 1, "R5");
        // R7: long acknowledge gives one strobe
        step(1, 1, 40, 30, 1, "R7");
        step(1, 1, 40, 30, 0, "R7");
        step(1, 1, 40, 32, 0, "R7");
        step(1, 1, 40, 32, 0, "R7");
        step(1, 1, 40, 32, 1, "R7");
        // R8: acknowledge with request idle
        step(1, 0, 60, 30, 1, "R8");
        step(1, 0, 60, 30, 0, "R8");
        step(1, 0, 60, 30, 1, "R8");
        // R6: disable abandons; re-enable between 2 and threshold stays idle
        step(1, 0, 10, 20, 1, "R6");
        step(1, 0, 10, 20, 1, "R6");
        step(0, 0, 10, 8, 1, "R6");
        step(1, 0, 10, 8, 1, "R6");
        step(1, 0, 10, 8, 1, "R6");
        // R8: acknowledge while enable low
        step(1, 0, 10, 20, 1, "R8");
        step(0, 0, 10, 20, 0, "R8");
        step(0, 0, 10, 20, 1, "R8");

        // random walk: R2 R3 R4 R5 R6 R7
        fl = 32; th = 16; tx = 0; en = 1; ack = 1; low_left = 0;
        for (int i = 0; i < 4000; i++) begin
            fl = fl + int'($urandom_range(0, 4)) - 2;
            if (fl < 0) fl = 0;
            if (fl > DEPTH) fl = DEPTH;
            if ($urandom_range(0, 59) == 0) th = int'($urandom_range(0, 70));
            if ($urandom_range(0, 299) == 0) tx = !tx;
            en = ($urandom_range(0, 99) != 0);
            if (low_left > 0) begin
                low_left--;
                ack = (low_left == 0);
            end else if ($urandom_range(0, 3) == 0) begin
                low_left = int'($urandom_range(1, 4));
                ack = 0;
            end else ack = 1;
            step(en, tx, th, fl, ack, "R2/R3/R4/R5/R6/R7");
        end
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule